// File: doc/BRIEF.md
# Compressed Instruction Expander and Classifier

This block turns one 16-bit compressed RV32 integer instruction into the equivalent 32-bit base instruction, in the same cycle it is presented. It sits between the fetch alignment stage and the main decoder, so that the decoder only ever sees full-width instructions. It is purely combinational and holds no state.

Along with the expansion it reports a class for every code point: legal, HINT, reserved, or reserved for custom use. Several opcodes have corner cases where an x0 register field or an all-zero immediate makes the code point mean something else. Such a code point may be the canonical no-op, a HINT, a reserved pattern, or a different instruction that shares the opcode, and the block resolves each one. HINTs still produce their harmless expansion. Reserved code points and opcodes this block does not implement raise an illegal flag. Inputs whose two low bits are both set are full-width instructions and are only flagged.

Top module: `rvc_expander`

## Requirements
- R1: While `valid_i` is low, `insn_o`, `class_o`, `illegal_o` and `not_comp_o` are all zero, whatever `insn_i` holds.
- R2: With `valid_i` high and `insn_i[1:0]` = 2'b11, `not_comp_o` is 1, `class_o` is 00 and `illegal_o` is 0. `insn_o` is don't-care in this case. For every other input `not_comp_o` is 0.
- R3: `class_o` encodes 00 legal, 01 HINT, 10 reserved, 11 custom-reserved. `illegal_o` is 1 exactly when `class_o[1]` is 1. Opcodes outside this block's set report class 10. Whenever `illegal_o` is 1, `insn_o` is zero. Legal and HINT code points output their 32-bit expansion.
- R4: The stack word load (quadrant 10, funct3 010) expands to `lw rd, off(x2)`. The offset is zero-extended: off[7:6]=insn[3:2], off[5]=insn[12], off[4:2]=insn[6:4]. A destination of x0 is reserved.
- R5: For quadrant 10, funct3 100 with insn[6:2]=0, the expansion depends on insn[12]. With insn[12]=0 it is `jalr x0,0(rs1)`, and rs1=x0 is reserved. With insn[12]=1 it is `jalr x1,0(rs1)`, and rs1=x0 gives EBREAK (0x00100073), which is legal.
- R6: The load-immediate form (quadrant 01, funct3 010) expands to `addi rd,x0,imm`, with imm the sign-extended value {insn[12],insn[6:2]}. rd=x0 is a HINT.
- R7: For quadrant 01, funct3 011, an all-zero {insn[12],insn[6:2]} is reserved. Otherwise rd=x2 gives `addi x2,x2,imm`, where imm is sign-extended with imm[9]=insn[12], imm[4]=insn[6], imm[6]=insn[5], imm[8:7]=insn[4:3], imm[5]=insn[2]. Any other rd gives `lui rd` with {insn[12],insn[6:2]} sign-extended into result bits 31..12, and rd=x0 is a HINT.
- R8: The register-immediate add (quadrant 01, funct3 000) expands to `addi rd,rd,imm`. rd=x0 with a zero immediate is the legal NOP 0x00000013. Any other code point with rd=x0 or a zero immediate is a HINT.
- R9: The stack address form (quadrant 00, funct3 000) expands to `addi rd',x2,u`, where rd' = x8+insn[4:2] and the zero-extended u has u[9:6]=insn[10:7], u[5:4]=insn[12:11], u[3]=insn[5], u[2]=insn[6]. A value of u=0 is reserved.
- R10: The left shift (quadrant 10, funct3 000) and the right shifts (quadrant 01, funct3 100, insn[11:10]=00 logical, 01 arithmetic) take their shift amount from insn[6:2]. The right shifts act on x8+insn[9:7]. insn[12]=1 is custom-reserved. Otherwise a zero shift amount is a HINT, and so is a left shift with rd=x0.
- R11: For quadrant 10, funct3 100 with insn[6:2]≠0, insn[12]=0 expands to `add rd,x0,rs2` and insn[12]=1 expands to `add rd,rd,rs2`. rd=x0 is a HINT in both cases.
- R12: The compact AND-immediate (quadrant 01, funct3 100, insn[11:10]=10) expands to `andi rd',rd',imm` on x8+insn[9:7] and is always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Input instruction is present |
| insn_i | input | 16 | Compressed instruction |
| insn_o | output | 32 | Expanded base instruction |
| class_o | output | 2 | 00 legal, 01 HINT, 10 reserved, 11 custom-reserved |
| illegal_o | output | 1 | Code point must trap |
| not_comp_o | output | 1 | Input is a full-width instruction |

## Verification
The block has no state, so an error can only be a wrong decode, and it shows at the ports in the same cycle as the input. A swapped immediate bit shows as a wrong `insn_o`. A missed corner case shows as a wrong `class_o` or `illegal_o`. Each of these is bounded to the code points that trigger it. Because of this, all 65536 input patterns are applied and compared against an independent decode. Directed vectors pin down the aliasing corner cases first, so that a failure names the rule that was broken.

// File: rtl/rvc_expander.sv
module rvc_expander (
  input  logic        valid_i,
  input  logic [15:0] insn_i,
  output logic [31:0] insn_o,
  output logic [1:0]  class_o,
  output logic        illegal_o,
  output logic        not_comp_o
);
  localparam logic [1:0] CL_LEGAL  = 2'b00;
  localparam logic [1:0] CL_HINT   = 2'b01;
  localparam logic [1:0] CL_RSVD   = 2'b10;
  localparam logic [1:0] CL_CUSTOM = 2'b11;

  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_LOAD = 7'b0000011;
  localparam logic [6:0] OP_LUI  = 7'b0110111;
  localparam logic [6:0] OP_JALR = 7'b1100111;
  localparam logic [31:0] EBREAK = 32'h0010_0073;

  logic [2:0]  f3;
  logic [4:0]  rd, rs2, rdc, rs1c;
  logic [11:0] imm6;
  logic        imm_zero;
  logic [9:0]  u4spn;
  logic [9:0]  i16sp;
  logic [7:0]  offsp;
  logic [31:0] exp_w;
  logic [1:0]  cls;
  logic        nc;

  assign f3       = insn_i[15:13];
  assign rd       = insn_i[11:7];
  assign rs2      = insn_i[6:2];
  assign rdc      = {2'b01, insn_i[4:2]};
  assign rs1c     = {2'b01, insn_i[9:7]};
  assign imm6     = {{6{insn_i[12]}}, insn_i[12], insn_i[6:2]};
  assign imm_zero = ({insn_i[12], insn_i[6:2]} == 6'd0);
  assign u4spn    = {insn_i[10:7], insn_i[12:11], insn_i[5], insn_i[6], 2'b00};
  assign i16sp    = {insn_i[12], insn_i[4:3], insn_i[5], insn_i[2], insn_i[6], 4'b0000};
  assign offsp    = {insn_i[3:2], insn_i[12], insn_i[6:4], 2'b00};

  always_comb begin
    exp_w = 32'd0;
    cls   = CL_LEGAL;
    nc    = 1'b0;
    unique case (insn_i[1:0])
      2'b00: begin
        if (f3 == 3'b000) begin
          exp_w = {2'b00, u4spn, 5'd2, 3'b000, rdc, OP_IMM};
          if (u4spn == 10'd0) cls = CL_RSVD;
        end else begin
          cls = CL_RSVD;
        end
      end
      2'b01: begin
        unique case (f3)
          3'b000: begin
            exp_w = {imm6, rd, 3'b000, rd, OP_IMM};
            if (rd == 5'd0 && imm_zero) cls = CL_LEGAL;
            else if (rd == 5'd0 || imm_zero) cls = CL_HINT;
          end
          3'b010: begin
            exp_w = {imm6, 5'd0, 3'b000, rd, OP_IMM};
            if (rd == 5'd0) cls = CL_HINT;
          end
          3'b011: begin
            if (imm_zero) cls = CL_RSVD;
            else if (rd == 5'd2)
              exp_w = {{2{i16sp[9]}}, i16sp, 5'd2, 3'b000, 5'd2, OP_IMM};
            else begin
              exp_w = {{14{insn_i[12]}}, insn_i[12], insn_i[6:2], rd, OP_LUI};
              if (rd == 5'd0) cls = CL_HINT;
            end
          end
          3'b100: begin
            unique case (insn_i[11:10])
              2'b00, 2'b01: begin
                exp_w = {1'b0, insn_i[10], 5'd0, insn_i[6:2], rs1c, 3'b101, rs1c, OP_IMM};
                if (insn_i[12]) cls = CL_CUSTOM;
                else if (rs2 == 5'd0) cls = CL_HINT;
              end
              2'b10: exp_w = {imm6, rs1c, 3'b111, rs1c, OP_IMM};
              default: cls = CL_RSVD;
            endcase
          end
          default: cls = CL_RSVD;
        endcase
      end
      2'b10: begin
        unique case (f3)
          3'b000: begin
            exp_w = {7'd0, insn_i[6:2], rd, 3'b001, rd, OP_IMM};
            if (insn_i[12]) cls = CL_CUSTOM;
            else if (rs2 == 5'd0 || rd == 5'd0) cls = CL_HINT;
          end
          3'b010: begin
            exp_w = {4'd0, offsp, 5'd2, 3'b010, rd, OP_LOAD};
            if (rd == 5'd0) cls = CL_RSVD;
          end
          3'b100: begin
            if (rs2 == 5'd0) begin
              if (rd == 5'd0) begin
                if (insn_i[12]) exp_w = EBREAK;
                else cls = CL_RSVD;
              end else begin
                exp_w = {12'd0, rd, 3'b000, 4'd0, insn_i[12], OP_JALR};
              end
            end else begin
              exp_w = {7'd0, rs2, (insn_i[12] ? rd : 5'd0), 3'b000, rd, OP_REG};
              if (rd == 5'd0) cls = CL_HINT;
            end
          end
          default: cls = CL_RSVD;
        endcase
      end
      default: nc = 1'b1;
    endcase
    if (cls[1]) exp_w = 32'd0;
  end

  assign insn_o     = valid_i ? exp_w : 32'd0;
  assign class_o    = valid_i ? cls : CL_LEGAL;
  assign illegal_o  = valid_i & cls[1];
  assign not_comp_o = valid_i & nc;

  always_comb begin
    if (!valid_i)
      assert_idle_quiet_R1: assert (insn_o == 32'd0 && class_o == 2'b00 && !illegal_o && !not_comp_o);
    if (not_comp_o)
      assert_full_width_clean_R2: assert (class_o == CL_LEGAL && !illegal_o && insn_i[1:0] == 2'b11);
    if (illegal_o)
      assert_illegal_no_expansion_R3: assert (insn_o == 32'd0);
    if (valid_i && !illegal_o && !not_comp_o)
      assert_expansion_full_width_R3: assert (insn_o[1:0] == 2'b11);
    if (valid_i && class_o == CL_CUSTOM)
      assert_custom_only_shifts_R10: assert (insn_i[12] && (insn_i[1:0] != 2'b00) && (insn_i[15:13] == 3'b000 || insn_i[15:13] == 3'b100));
  end
endmodule

// File: tb/rvc_expander_tb.sv
module rvc_expander_tb;
  logic        clk = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] insn_i = 16'd0;
  logic [31:0] insn_o;
  logic [1:0]  class_o;
  logic        illegal_o;
  logic        not_comp_o;

  int applied = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rvc_expander u_dut (
    .valid_i(valid_i), .insn_i(insn_i), .insn_o(insn_o),
    .class_o(class_o), .illegal_o(illegal_o), .not_comp_o(not_comp_o)
  );

  // {insn, expected expansion, class, illegal}
  localparam int NV = 13;
  localparam logic [50:0] VEC [NV] = '{
    {16'h0001, 32'h0000_0013, 2'b00, 1'b0},   // R8 NOP
    {16'h0085, 32'h0010_8093, 2'b00, 1'b0},   // R8 addi x1,x1,1
    {16'h0000, 32'h0000_0000, 2'b10, 1'b1},   // R9 zero immediate
    {16'h4005, 32'h0010_0013, 2'b01, 1'b0},   // R6 li x0 hint
    {16'h9002, 32'h0010_0073, 2'b00, 1'b0},   // R5 ebreak
    {16'h8002, 32'h0000_0000, 2'b10, 1'b1},   // R5 jr x0
    {16'h1082, 32'h0000_0000, 2'b11, 1'b1},   // R10 shamt[5]
    {16'h808A, 32'h0020_00B3, 2'b00, 1'b0},   // R11 mv x1,x2
    {16'h4092, 32'h0041_2083, 2'b00, 1'b0},   // R4 lw x1,4(x2)
    {16'h717D, 32'hFF01_0113, 2'b00, 1'b0},   // R7 addi x2,x2,-16
    {16'h6085, 32'h0000_10B7, 2'b00, 1'b0},   // R7 lui x1,1
    {16'h0040, 32'h0041_0413, 2'b00, 1'b0},   // R9 addi x8,x2,4
    {16'h8401, 32'h4004_5413, 2'b01, 1'b0}    // R10 srai x8,0 hint
  };

  function automatic string req_of(input logic [15:0] c);
    if (c[1:0] == 2'b11) return "R2";
    case ({c[1:0], c[15:13]})
      5'b00_000: return "R9";
      5'b01_000: return "R8";
      5'b01_010: return "R6";
      5'b01_011: return "R7";
      5'b01_100: return (c[11:10] == 2'b10) ? "R12" : (c[11] ? "R3" : "R10");
      5'b10_000: return "R10";
      5'b10_010: return "R4";
      5'b10_100: return (c[6:2] == 5'd0) ? "R5" : "R11";
      default:   return "R3";
    endcase
  endfunction

  // independent reference: returns {expansion, class, illegal}
  function automatic logic [34:0] ref_decode(input logic [15:0] c);
    logic [31:0] e;
    logic [1:0]  k;
    logic [4:0]  r, s, cp, cq;
    logic [5:0]  i6;
    logic [11:0] se;
    e = 32'd0; k = 2'b00;
    r = c[11:7]; s = c[6:2];
    cp = 5'd8 + {2'b00, c[4:2]};
    cq = 5'd8 + {2'b00, c[9:7]};
    i6 = {c[12], c[6:2]};
    se = {{6{i6[5]}}, i6};
    if (c[1:0] == 2'b00 && c[15:13] == 3'b000) begin
      logic [11:0] u;
      u = 12'd0;
      u[9:6] = c[10:7]; u[5:4] = c[12:11]; u[3] = c[5]; u[2] = c[6];
      if (u == 0) k = 2'b10;
      else e = (32'(u) << 20) | (32'd2 << 15) | (32'(cp) << 7) | 32'h13;
    end else if (c[1:0] == 2'b01 && c[15:13] == 3'b000) begin
      e = {se, r, 3'b000, r, 7'h13};
      if ((r == 0) != (i6 == 0)) k = 2'b01;
    end else if (c[1:0] == 2'b01 && c[15:13] == 3'b010) begin
      e = {se, 5'd0, 3'b000, r, 7'h13};
      k = (r == 0) ? 2'b01 : 2'b00;
    end else if (c[1:0] == 2'b01 && c[15:13] == 3'b011) begin
      if (i6 == 0) k = 2'b10;
      else if (r == 5'd2) begin
        logic signed [11:0] a;
        a = 12'(signed'(i6)) * 12'sd0;
        a[9] = c[12]; a[8:7] = c[4:3]; a[6] = c[5]; a[5] = c[2]; a[4] = c[6];
        a[11:10] = {2{c[12]}};
        e = {a, 5'd2, 3'b000, 5'd2, 7'h13};
      end else begin
        e = {{14{c[12]}}, i6, r, 7'h37};
        if (r == 0) k = 2'b01;
      end
    end else if (c[1:0] == 2'b01 && c[15:13] == 3'b100 && !c[11]) begin
      if (c[12]) k = 2'b11;
      else begin
        e = {1'b0, c[10], 5'd0, s, cq, 3'b101, cq, 7'h13};
        if (s == 0) k = 2'b01;
      end
    end else if (c[1:0] == 2'b01 && c[15:13] == 3'b100 && c[11:10] == 2'b10) begin
      e = {se, cq, 3'b111, cq, 7'h13};
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b000) begin
      if (c[12]) k = 2'b11;
      else begin
        e = {7'd0, s, r, 3'b001, r, 7'h13};
        if (s == 0 || r == 0) k = 2'b01;
      end
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b010) begin
      if (r == 0) k = 2'b10;
      else e = {4'd0, c[3:2], c[12], c[6:4], 2'b00, 5'd2, 3'b010, r, 7'h03};
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b100) begin
      if (s != 0) begin
        e = {7'd0, s, c[12] ? r : 5'd0, 3'b000, r, 7'h33};
        if (r == 0) k = 2'b01;
      end else if (r == 0) begin
        if (c[12]) e = 32'h0010_0073;
        else k = 2'b10;
      end else begin
        e = {12'd0, r, 3'b000, 4'd0, c[12], 7'h67};
      end
    end else if (c[1:0] != 2'b11) begin
      k = 2'b10;
    end
    return {e, k, k[1]};
  endfunction

  task automatic apply(input logic v, input logic [15:0] c, input logic [31:0] ee,
                       input logic [1:0] ek, input logic ei, input logic enc,
                       input logic chk_exp, input string req);
    @(posedge clk);
    valid_i = v;
    insn_i  = c;
    @(negedge clk);
    applied++;
    if ((chk_exp && insn_o !== ee) || class_o !== ek || illegal_o !== ei || not_comp_o !== enc) begin
      fails++;
      $display("FAIL %s insn=%h: got exp=%h cls=%b ill=%b nc=%b, want exp=%h cls=%b ill=%b nc=%b",
               req, c, insn_o, class_o, illegal_o, not_comp_o, ee, ek, ei, enc);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang, want finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    // R1: idle output state, including with a non-zero instruction present
    apply(1'b0, 16'h0000, 32'd0, 2'b00, 1'b0, 1'b0, 1'b1, "R1");
    apply(1'b0, 16'h9002, 32'd0, 2'b00, 1'b0, 1'b0, 1'b1, "R1");
    apply(1'b0, 16'hFFFF, 32'd0, 2'b00, 1'b0, 1'b0, 1'b1, "R1");

    for (int i = 0; i < NV; i++)
      apply(1'b1, VEC[i][50:35], VEC[i][34:3], VEC[i][2:1], VEC[i][0], 1'b0, 1'b1,
            req_of(VEC[i][50:35]));

    // R2: full-width inputs
    apply(1'b1, 16'h0003, 32'd0, 2'b00, 1'b0, 1'b1, 1'b0, "R2");
    apply(1'b1, 16'hFFFF, 32'd0, 2'b00, 1'b0, 1'b1, 1'b0, "R2");
    // R3: unimplemented opcode (compact store word) traps
    apply(1'b1, 16'hC000, 32'd0, 2'b10, 1'b1, 1'b0, 1'b1, "R3");
    // R12: andi x8,x8,-1
    apply(1'b1, 16'h987D, 32'hFFF4_7413, 2'b00, 1'b0, 1'b0, 1'b1, "R12");

    for (int i = 0; i < 65536; i++) begin
      logic [34:0] r;
      logic [15:0] c;
      c = 16'(i);
      r = ref_decode(c);
      apply(1'b1, c, r[34:3], r[2:1], r[0], c[1:0] == 2'b11, c[1:0] != 2'b11, req_of(c));
    end

    apply(1'b0, 16'h0085, 32'd0, 2'b00, 1'b0, 1'b0, 1'b1, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule